// File: doc/BRIEF.md
# Two-Copy Set-Associative Page Translation Lookup

This block translates a virtual address into a physical frame through a page table cache. The cache has a separate copy for instruction fetches and for data accesses. Each copy is four ways deep and sixteen entries per way. One lookup request gives an address, an access kind (read, write or execute), a user/kernel flag, an 8-bit process tag and a configuration word. The block reads the entry at index VPN[3:0] in every way of the chosen copy. It picks the lowest way that matches, then runs the protection checks in a fixed priority. One cycle later it returns the hit flag, the physical address, the granted permissions, the matching way and an exception vector number.

Software fills entries through a write port. The port selects the copy, the way and the index, and supplies a tag word and a data word. Refill selection and fault recording belong to the surrounding logic.

Top module: `xlat_tlb`

## Requirements
- R1: A response (rspValid high) appears in the clock cycle after each cycle with reqValid high, and at no other time. rspValid is low during and after reset until the first request.
- R2: Execute accesses (reqType 2) use the instruction copy (wrTlb 0), and the vector base is 4. Reads (reqType 0) and writes (reqType 1) use the data copy (wrTlb 1), and the vector base is 8.
- R3: The pages are 8 KB, so the VPN is address bits 31:13 and the index is VPN[3:0]. In the tag word, bits 31:13 hold the VPN and bits 7:0 hold the process tag. An entry matches when its VPN equals the access VPN and either its global bit (data word bit 4) is set or its tag equals reqPid.
- R4: When several ways match, the lowest-numbered way is used. rspSet reports that way, or 0 when no way matches.
- R5: When no way matches, rspHit is 0, rspVector is base+0, and rspPerm and rspPaddr are 0.
- R6: On a match with configuration bit 18 set, a user access to an entry whose kernel bit (data word bit 2) is set fails with base+2. This check has the highest priority.
- R7: On a match with configuration bit 19 set, a write to an entry whose write bit (data word bit 1) is clear fails with base+3. This check is second in priority.
- R8: On a match with configuration bit 17 set, an execute from an entry whose execute bit (data word bit 0) is clear fails with base+3. This check is third in priority.
- R9: On a match with configuration bit 16 set, an entry whose valid bit (data word bit 3) is clear fails with base+1. This check has the lowest priority.
- R10: A check whose configuration bit is clear has no effect on the result.
- R11: On a successful translation, rspHit is 1 and rspVector is base+0. rspPerm bit 0 (read) is 1, bit 1 (write) copies the entry's write bit, and bit 2 (execute) copies its execute bit. On a failed check, rspHit and rspPerm are 0.
- R12: On a successful translation, rspPaddr is the entry's frame number (data word bits 31:13) followed by address bits 12:0.
- R13: An entry written in one cycle is seen by lookups from the next cycle on. A lookup in the same cycle as the write sees the old content. A write to one copy leaves the other copy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Lookup request |
| reqAddr | input | 32 | Virtual address |
| reqType | input | 2 | 0 read, 1 write, 2 execute |
| reqUser | input | 1 | Access made in user mode |
| reqPid | input | 8 | Current process tag |
| cfgWord | input | 32 | Check enables: bits 19 write, 18 kernel, 17 execute, 16 valid |
| wrEn | input | 1 | Entry write strobe |
| wrTlb | input | 1 | Copy to write: 0 instruction, 1 data |
| wrSet | input | 2 | Way to write |
| wrIdx | input | 4 | Index to write |
| wrHi | input | 32 | Tag word |
| wrLo | input | 32 | Data word |
| rspValid | output | 1 | Response valid |
| rspHit | output | 1 | Translation succeeded |
| rspPaddr | output | 32 | Physical address |
| rspPerm | output | 3 | Granted read, write, execute (bits 0, 1, 2) |
| rspSet | output | 2 | Matching way |
| rspVector | output | 4 | Exception vector number |

## Verification
The bench uses the default parameters: four ways, sixteen indices, 32-bit addresses and 8 KB pages. With these values a single index can hold entries in several ways with the same VPN, so the bench checks that the lowest way wins over a global entry in a higher way. Addresses that share an index but differ in the upper VPN bits give true misses. Both copies hold entries at the same index, which shows that the access kind picks the copy. The four-way depth and the 2-bit way field make it possible to write to way 3 and to read that way number back.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } accKind_e;

  // data word flag positions
  localparam int LO_GLOBAL = 4;
  localparam int LO_VALID  = 3;
  localparam int LO_KERNEL = 2;
  localparam int LO_WRITE  = 1;
  localparam int LO_EXEC   = 0;

  // configuration word check enables
  localparam int CFG_WCHK = 19;
  localparam int CFG_KCHK = 18;
  localparam int CFG_XCHK = 17;
  localparam int CFG_VCHK = 16;

  localparam logic [3:0] VEC_BASE_INSN = 4'd4;
  localparam logic [3:0] VEC_BASE_DATA = 4'd8;

  typedef struct packed {
    logic       load;
    logic       hit;
    logic [3:0] vector;
    logic [2:0] perm;
  } xlatStrobe_t;

endpackage

// File: rtl/xlat_tlb_store.sv
module xlat_tlb_store
  import xlat_pkg::*;
#(
  parameter int WAYS    = 4,
  parameter int IDX     = 16,
  parameter int VA_W    = 32,
  parameter int PG_BITS = 13,
  parameter int PID_W   = 8,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int IDX_W  = $clog2(IDX)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [VA_W-1:0]            reqAddr,
  input  logic [1:0]                 reqType,
  input  logic [PID_W-1:0]           reqPid,
  input  logic                       wrEn,
  input  logic                       wrTlb,
  input  logic [WAY_W-1:0]           wrSet,
  input  logic [IDX_W-1:0]           wrIdx,
  input  logic [VA_W-1:0]            wrHi,
  input  logic [VA_W-1:0]            wrLo,
  input  xlatStrobe_t                strobe,
  input  logic [WAY_W-1:0]           selWay,
  output logic [WAYS-1:0]            matchVec,
  output logic [WAYS-1:0][VA_W-1:0]  wayLo,
  output logic                       rspValid,
  output logic                       rspHit,
  output logic [VA_W-1:0]            rspPaddr,
  output logic [2:0]                 rspPerm,
  output logic [WAY_W-1:0]           rspSet,
  output logic [3:0]                 rspVector
);

  localparam int VPN_W = VA_W - PG_BITS;

  logic [VA_W-1:0] hiMem [2][WAYS][IDX];
  logic [VA_W-1:0] loMem [2][WAYS][IDX];

  logic             tlbSel;
  logic [IDX_W-1:0] rdIdx;
  logic [VPN_W-1:0] reqVpn;

  assign tlbSel = (reqType == ACC_EXEC) ? 1'b0 : 1'b1;
  assign rdIdx  = reqAddr[PG_BITS +: IDX_W];
  assign reqVpn = reqAddr[VA_W-1:PG_BITS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int t = 0; t < 2; t++)
        for (int w = 0; w < WAYS; w++)
          for (int i = 0; i < IDX; i++) begin
            hiMem[t][w][i] <= '0;
            loMem[t][w][i] <= '0;
          end
    end else if (wrEn) begin
      hiMem[wrTlb][wrSet][wrIdx] <= wrHi;
      loMem[wrTlb][wrSet][wrIdx] <= wrLo;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [VA_W-1:0] wayHi;
    logic            tagEq;
    logic            pidOk;
    assign wayHi       = hiMem[tlbSel][w][rdIdx];
    assign wayLo[w]    = loMem[tlbSel][w][rdIdx];
    assign tagEq       = (wayHi[VA_W-1:PG_BITS] == reqVpn);
    assign pidOk       = wayLo[w][LO_GLOBAL] || (wayHi[PID_W-1:0] == reqPid);
    assign matchVec[w] = tagEq && pidOk;
  end

  logic [VA_W-1:0] selLo;
  logic [VA_W-1:0] physNext;
  assign selLo    = wayLo[selWay];
  assign physNext = {selLo[VA_W-1:PG_BITS], reqAddr[PG_BITS-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspHit    <= 1'b0;
      rspPaddr  <= '0;
      rspPerm   <= '0;
      rspSet    <= '0;
      rspVector <= '0;
    end else begin
      rspValid <= strobe.load;
      if (strobe.load) begin
        rspHit    <= strobe.hit;
        rspPaddr  <= strobe.hit ? physNext : '0;
        rspPerm   <= strobe.perm;
        rspSet    <= selWay;
        rspVector <= strobe.vector;
      end
    end
  end

endmodule

// File: rtl/xlat_tlb_ctrl.sv
module xlat_tlb_ctrl
  import xlat_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int VA_W   = 32,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                      reqValid,
  input  logic [1:0]                reqType,
  input  logic                      reqUser,
  input  logic [31:0]               cfgWord,
  input  logic [WAYS-1:0]           matchVec,
  input  logic [WAYS-1:0][VA_W-1:0] wayLo,
  output xlatStrobe_t               strobe,
  output logic [WAY_W-1:0]          selWay
);

  logic            anyMatch;
  logic [VA_W-1:0] lo;
  logic [3:0]      base;
  logic            isWrite;
  logic            isExec;

  // lowest matching way wins
  always_comb begin
    anyMatch = 1'b0;
    selWay   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (matchVec[w]) begin
        anyMatch = 1'b1;
        selWay   = WAY_W'(w);
      end
    end
  end

  assign lo      = wayLo[selWay];
  assign isWrite = (reqType == ACC_WRITE);
  assign isExec  = (reqType == ACC_EXEC);
  assign base    = isExec ? VEC_BASE_INSN : VEC_BASE_DATA;

  always_comb begin
    logic ok;
    logic [3:0] vec;
    ok  = anyMatch;
    vec = base;
    if (anyMatch) begin
      if (cfgWord[CFG_KCHK] && lo[LO_KERNEL] && reqUser) begin
        ok  = 1'b0;
        vec = base + 4'd2;
      end else if (isWrite && cfgWord[CFG_WCHK] && !lo[LO_WRITE]) begin
        ok  = 1'b0;
        vec = base + 4'd3;
      end else if (isExec && cfgWord[CFG_XCHK] && !lo[LO_EXEC]) begin
        ok  = 1'b0;
        vec = base + 4'd3;
      end else if (cfgWord[CFG_VCHK] && !lo[LO_VALID]) begin
        ok  = 1'b0;
        vec = base + 4'd1;
      end
    end
    strobe.load   = reqValid;
    strobe.hit    = ok;
    strobe.vector = vec;
    strobe.perm   = ok ? {lo[LO_EXEC], lo[LO_WRITE], 1'b1} : 3'b000;
  end

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_pkg::*;
#(
  parameter int WAYS    = 4,
  parameter int IDX     = 16,
  parameter int VA_W    = 32,
  parameter int PG_BITS = 13,
  parameter int PID_W   = 8,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int IDX_W  = $clog2(IDX)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [VA_W-1:0]    reqAddr,
  input  logic [1:0]         reqType,
  input  logic               reqUser,
  input  logic [PID_W-1:0]   reqPid,
  input  logic [31:0]        cfgWord,
  input  logic               wrEn,
  input  logic               wrTlb,
  input  logic [WAY_W-1:0]   wrSet,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [VA_W-1:0]    wrHi,
  input  logic [VA_W-1:0]    wrLo,
  output logic               rspValid,
  output logic               rspHit,
  output logic [VA_W-1:0]    rspPaddr,
  output logic [2:0]         rspPerm,
  output logic [WAY_W-1:0]   rspSet,
  output logic [3:0]         rspVector
);

  xlatStrobe_t               strobe;
  logic [WAY_W-1:0]          selWay;
  logic [WAYS-1:0]           matchVec;
  logic [WAYS-1:0][VA_W-1:0] wayLo;

  xlat_tlb_ctrl #(.WAYS(WAYS), .VA_W(VA_W)) u_ctrl (
    .reqValid (reqValid),
    .reqType  (reqType),
    .reqUser  (reqUser),
    .cfgWord  (cfgWord),
    .matchVec (matchVec),
    .wayLo    (wayLo),
    .strobe   (strobe),
    .selWay   (selWay)
  );

  xlat_tlb_store #(
    .WAYS(WAYS), .IDX(IDX), .VA_W(VA_W), .PG_BITS(PG_BITS), .PID_W(PID_W)
  ) u_store (
    .clk       (clk),
    .rstN      (rstN),
    .reqAddr   (reqAddr),
    .reqType   (reqType),
    .reqPid    (reqPid),
    .wrEn      (wrEn),
    .wrTlb     (wrTlb),
    .wrSet     (wrSet),
    .wrIdx     (wrIdx),
    .wrHi      (wrHi),
    .wrLo      (wrLo),
    .strobe    (strobe),
    .selWay    (selWay),
    .matchVec  (matchVec),
    .wayLo     (wayLo),
    .rspValid  (rspValid),
    .rspHit    (rspHit),
    .rspPaddr  (rspPaddr),
    .rspPerm   (rspPerm),
    .rspSet    (rspSet),
    .rspVector (rspVector)
  );

endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk #(
  parameter int VA_W    = 32,
  parameter int PG_BITS = 13
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic [VA_W-1:0] reqAddr,
  input logic [1:0]      reqType,
  input logic [31:0]     cfgWord,
  input logic            rspValid,
  input logic            rspHit,
  input logic [VA_W-1:0] rspPaddr,
  input logic [2:0]      rspPerm,
  input logic [3:0]      rspVector
);

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);  // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);  // R1
  AST_EXEC_VEC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqType == 2'd2 |=> rspVector[3:2] == 2'b01);  // R2
  AST_DATA_VEC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqType != 2'd2 |=> rspVector[3:2] == 2'b10);  // R2
  AST_MISS_NO_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspHit |-> rspPerm == 3'b000 && rspPaddr == '0);  // R5
  AST_WRITE_CHECK: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqType == 2'd1 && cfgWord[19] |=> !rspHit || rspPerm[1]);  // R7
  AST_EXEC_CHECK: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqType == 2'd2 && cfgWord[17] |=> !rspHit || rspPerm[2]);  // R8
  AST_HIT_READ_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspHit |-> rspPerm[0] && rspVector[1:0] == 2'b00);  // R11
  AST_PADDR_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> !rspHit || rspPaddr[PG_BITS-1:0] == $past(reqAddr[PG_BITS-1:0]));  // R12

endmodule

bind xlat_tlb xlat_tlb_chk #(.VA_W(VA_W), .PG_BITS(PG_BITS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqAddr   (reqAddr),
  .reqType   (reqType),
  .cfgWord   (cfgWord),
  .rspValid  (rspValid),
  .rspHit    (rspHit),
  .rspPaddr  (rspPaddr),
  .rspPerm   (rspPerm),
  .rspVector (rspVector)
);

// File: tb/tb_xlat_tlb.sv
module tb_xlat_tlb;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        hit;
    logic [31:0] paddr;
    logic [2:0]  perm;
    logic [1:0]  set;
    logic [3:0]  vector;
  } expT;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqType = '0;
  logic        reqUser = 1'b0;
  logic [7:0]  reqPid = '0;
  logic [31:0] cfgWord = '0;
  logic        wrEn = 1'b0;
  logic        wrTlb = 1'b0;
  logic [1:0]  wrSet = '0;
  logic [3:0]  wrIdx = '0;
  logic [31:0] wrHi = '0;
  logic [31:0] wrLo = '0;
  logic        rspValid;
  logic        rspHit;
  logic [31:0] rspPaddr;
  logic [2:0]  rspPerm;
  logic [1:0]  rspSet;
  logic [3:0]  rspVector;

  int testCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  expT   expQ[$];
  string tagQ[$];
  logic [31:0] hiS [2][4][16];
  logic [31:0] loS [2][4][16];

  localparam logic [31:0] CFG_ALL = 32'h000F_0000;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xlat_tlb dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqType(reqType), .reqUser(reqUser), .reqPid(reqPid), .cfgWord(cfgWord),
    .wrEn(wrEn), .wrTlb(wrTlb), .wrSet(wrSet), .wrIdx(wrIdx), .wrHi(wrHi),
    .wrLo(wrLo), .rspValid(rspValid), .rspHit(rspHit), .rspPaddr(rspPaddr),
    .rspPerm(rspPerm), .rspSet(rspSet), .rspVector(rspVector)
  );

  // expected result, derived from the requirement list
  function automatic expT model(logic [31:0] a, logic [1:0] k, logic u,
                                logic [7:0] p, logic [31:0] c);
    expT e;
    int  t;
    logic found;
    logic [31:0] lo;
    logic [3:0] base;
    t    = (k == 2'd2) ? 0 : 1;
    base = (k == 2'd2) ? 4'd4 : 4'd8;
    found = 1'b0;
    lo = '0;
    e = '0;
    e.vector = base;
    for (int s = 0; s < 4; s++) begin
      if (!found && hiS[t][s][a[16:13]][31:13] == a[31:13] &&
          (loS[t][s][a[16:13]][4] || hiS[t][s][a[16:13]][7:0] == p)) begin
        found = 1'b1;
        lo    = loS[t][s][a[16:13]];
        e.set = 2'(s);
      end
    end
    if (found) begin
      if (c[18] && lo[2] && u)              e.vector = base + 4'd2;
      else if (k == 2'd1 && c[19] && !lo[1]) e.vector = base + 4'd3;
      else if (k == 2'd2 && c[17] && !lo[0]) e.vector = base + 4'd3;
      else if (c[16] && !lo[3])             e.vector = base + 4'd1;
      else begin
        e.hit   = 1'b1;
        e.perm  = {lo[0], lo[1], 1'b1};
        e.paddr = {lo[31:13], a[12:0]};
      end
    end
    return e;
  endfunction

  task automatic writeEntry(logic t, logic [1:0] s, logic [3:0] i,
                            logic [31:0] hi, logic [31:0] lo);
    @(negedge clk);
    wrEn = 1'b1; wrTlb = t; wrSet = s; wrIdx = i; wrHi = hi; wrLo = lo;
    hiS[t][s][i] = hi;
    loS[t][s][i] = lo;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic lookup(logic [31:0] a, logic [1:0] k, logic u, logic [7:0] p,
                        logic [31:0] c, string tag);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqType = k; reqUser = u; reqPid = p; cfgWord = c;
    expQ.push_back(model(a, k, u, p, c));
    tagQ.push_back(tag);
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  // lookup and entry write in the same cycle: expectation uses old content
  task automatic lookupWhileWrite(logic [31:0] a, logic [7:0] p, logic [1:0] s,
                                  logic [31:0] hi, logic [31:0] lo, string tag);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqType = 2'd0; reqUser = 1'b0; reqPid = p;
    cfgWord = CFG_ALL;
    expQ.push_back(model(a, 2'd0, 1'b0, p, CFG_ALL));
    tagQ.push_back(tag);
    wrEn = 1'b1; wrTlb = 1'b1; wrSet = s; wrIdx = a[16:13]; wrHi = hi; wrLo = lo;
    hiS[1][s][a[16:13]] = hi;
    loS[1][s][a[16:13]] = lo;
    @(posedge clk);
    #1 begin reqValid = 1'b0; wrEn = 1'b0; end
  endtask

  // monitor: compares each response against the scoreboard
  always @(negedge clk) begin
    if (rstN && rspValid && !finished) begin
      testCount++;
      if (expQ.size() == 0) begin
        failCount++;
        $display("FAIL R1: unexpected response, actual rspValid=1 expected 0");
      end else begin
        expT e;
        expT got;
        string tg;
        e  = expQ.pop_front();
        tg = tagQ.pop_front();
        got = '{hit: rspHit, paddr: rspPaddr, perm: rspPerm, set: rspSet, vector: rspVector};
        if (got !== e) begin
          failCount++;
          $display("FAIL %s: actual hit=%0b pa=%h perm=%b set=%0d vec=%0d expected hit=%0b pa=%h perm=%b set=%0d vec=%0d",
                   tg, got.hit, got.paddr, got.perm, got.set, got.vector,
                   e.hit, e.paddr, e.perm, e.set, e.vector);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      failCount++;
      $display("FAIL watchdog: actual run still busy, expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < 2; t++)
      for (int s = 0; s < 4; s++)
        for (int i = 0; i < 16; i++) begin
          hiS[t][s][i] = '0;
          loS[t][s][i] = '0;
        end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    testCount++;
    if (rspValid !== 1'b0) begin
      failCount++;
      $display("FAIL R1: reset state actual rspValid=%b expected 0", rspValid);
    end

    // data copy, index 5, VPN 5: way 2 tag 0x11 rw valid, way 3 global
    writeEntry(1'b1, 2'd2, 4'd5, {19'h00005, 5'd0, 8'h11}, {19'h12345, 8'd0, 5'b01010});
    writeEntry(1'b1, 2'd3, 4'd5, {19'h00005, 5'd0, 8'h99}, {19'h54321, 8'd0, 5'b11011});
    // instruction copy, same index/VPN, executable
    writeEntry(1'b0, 2'd0, 4'd5, {19'h00005, 5'd0, 8'h11}, {19'h0AAAA, 8'd0, 5'b01001});
    // data copy, index 7: kernel page, read-only, invalid
    writeEntry(1'b1, 2'd1, 4'd7, {19'h10007, 5'd0, 8'h33}, {19'h07777, 8'd0, 5'b00100});
    // instruction copy, index 7: no exec, invalid
    writeEntry(1'b0, 2'd1, 4'd7, {19'h10007, 5'd0, 8'h33}, {19'h06666, 8'd0, 5'b00000});

    lookup(32'h0000_A123, 2'd0, 1'b0, 8'h11, CFG_ALL, "R4 lowest way wins");
    lookup(32'h0000_BFFF, 2'd1, 1'b1, 8'h22, CFG_ALL, "R3 global match");
    lookup(32'h0000_A456, 2'd2, 1'b0, 8'h11, CFG_ALL, "R2 exec uses insn copy");
    lookup(32'h0002_A000, 2'd0, 1'b0, 8'h11, CFG_ALL, "R5 data miss");
    lookup(32'h0002_A000, 2'd2, 1'b0, 8'h11, CFG_ALL, "R5 exec miss");
    lookup(32'h2000_E010, 2'd0, 1'b0, 8'h34, CFG_ALL, "R3 tag mismatch");
    lookup(32'h2000_E010, 2'd1, 1'b1, 8'h33, CFG_ALL, "R6 kernel first");
    lookup(32'h2000_E010, 2'd1, 1'b0, 8'h33, CFG_ALL, "R7 write before valid");
    lookup(32'h2000_E010, 2'd0, 1'b0, 8'h33, CFG_ALL, "R9 invalid entry");
    lookup(32'h2000_E010, 2'd1, 1'b1, 8'h33, 32'h0, "R10 checks off");
    lookup(32'h2000_E010, 2'd2, 1'b0, 8'h33, CFG_ALL, "R8 exec denied");
    lookup(32'h2000_E010, 2'd2, 1'b0, 8'h33, 32'h0001_0000, "R9 exec invalid");
    lookup(32'h0000_A001, 2'd1, 1'b0, 8'h11, CFG_ALL, "R11 R12 write grant");
    // same-cycle write then lookup, data copy index 9
    lookupWhileWrite(32'h0001_3008, 8'h44, 2'd0,
                     {19'h00009, 5'd0, 8'h44}, {19'h3ABCD, 8'd0, 5'b01011},
                     "R13 old content in write cycle");
    lookup(32'h0001_3008, 2'd0, 1'b0, 8'h44, CFG_ALL, "R13 new entry visible");
    lookup(32'h0001_3008, 2'd2, 1'b0, 8'h44, CFG_ALL, "R13 other copy untouched");

    repeat (4) @(negedge clk);
    testCount++;
    if (expQ.size() != 0) begin
      failCount++;
      $display("FAIL R1: actual %0d responses missing, expected 0", expQ.size());
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule